// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel data buses, A and B, and moves data between them in either direction without inverting it. Each bus appears as separate input, output and output-enable signals, so the block has no tri-state nets inside it. For each direction the block has a capture register, a source select and an output enable. A direction can forward the live value of the opposite bus, or it can forward the word held in its own register.

The two registers are independent. A capture strobe, sampled on the rising edge of the shared clock, loads each one. A capture takes place whatever the selects and enables are set to. The A-to-B enable is active high and the B-to-A enable is active low. With both enabled and both selects set to stored, the held A word goes onto B and the held B word goes onto A in the same cycle. With both enabled and both selects set to live, each bus drives the other. In that state a keeper register holds the value that was on the buses just before the loop closed, and the external inputs have no effect.

The rest of the chip uses the block to bridge two bus segments. It can also park a word in either direction and replay it later.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: A clock edge with `rst` high clears both capture registers and the keeper register to zero.
- R2: A clock edge with `cap_ab` high loads the A-to-B register from the resolved A bus (`a_out` when `a_oe` is 1, otherwise `a_in`), whatever the selects and enables are. With `cap_ab` low the register keeps its value.
- R3: A clock edge with `cap_ba` high loads the B-to-A register from the resolved B bus (`b_out` when `b_oe` is 1, otherwise `b_in`), whatever the selects and enables are. With `cap_ba` low the register keeps its value.
- R4: `b_oe` equals `oe_ab`, which is active high. When `b_oe` is 1 and `sel_ab` is 0 (live), `b_out` is the resolved A bus. When `b_oe` is 1 and `sel_ab` is 1 (stored), `b_out` is the A-to-B register.
- R5: `a_oe` equals the inverse of `oe_ba_n`, which is active low. When `a_oe` is 1 and `sel_ba` is 0 (live), `a_out` is the resolved B bus. When `a_oe` is 1 and `sel_ba` is 1 (stored), `a_out` is the B-to-A register.
- R6: When a bus is not enabled, its output is zero and its output enable is 0.
- R7: With `oe_ab`=1, `oe_ba_n`=0, `sel_ab`=1 and `sel_ba`=1, `b_out` shows the A-to-B register and `a_out` shows the B-to-A register in the same cycle.
- R8: Data is never inverted. When one direction is live and the other is stored, the live direction passes on the stored word driven onto its source bus.
- R9: While both directions are enabled and live, `a_out` and `b_out` both equal the resolved A bus value from the last clock edge before the loop closed. They stay at that value whatever `a_in` and `b_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Value driven onto bus A by other agents |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | W | Value driven onto bus B by other agents |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |
| cap_ab | input | 1 | Load the A-to-B register at this clock edge |
| cap_ba | input | 1 | Load the B-to-A register at this clock edge |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| oe_ab | input | 1 | A-to-B enable, active high |
| oe_ba_n | input | 1 | B-to-A enable, active low |

## Verification
The assertions assume that control inputs change only away from the rising edge and are stable when the edge samples them. They also assume that `a_in` and `b_in` are ignored while the block drives the same bus. For the loop-hold property, they assume that the loop is entered from a state the keeper has already sampled. The stimulus drives every input on the falling edge. It treats a driven bus's external input as irrelevant. It walks all sixteen enable/select combinations with random data. For the hold case, it sets up one live direction for a full cycle before closing the loop, then changes both external inputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Source chosen by a direction's select input
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/xcvr_bus_resolve.sv
module xcvr_bus_resolve
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         en_ab,
  input  logic         en_ba,
  input  src_sel_e     src_ab,
  input  src_sel_e     src_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] q_ab,
  input  logic [W-1:0] q_ba,
  input  logic [W-1:0] keep,
  output logic [W-1:0] a_bus,
  output logic [W-1:0] b_bus,
  output logic         loop
);
  logic live_ab, live_ba;

  assign live_ab = en_ab && (src_ab == SRC_LIVE);
  assign live_ba = en_ba && (src_ba == SRC_LIVE);
  assign loop    = live_ab && live_ba;

  // Each case is written out so the netlist has no combinational cycle
  always_comb begin
    if (loop) begin
      a_bus = keep;
      b_bus = keep;
    end else begin
      if (!en_ba)        a_bus = a_in;
      else if (!live_ba) a_bus = q_ba;
      else if (en_ab)    a_bus = q_ab;   // B side is stored-driven
      else               a_bus = b_in;

      if (!en_ab)        b_bus = b_in;
      else if (!live_ab) b_bus = q_ab;
      else if (en_ba)    b_bus = q_ba;   // A side is stored-driven
      else               b_bus = a_in;
    end
  end
endmodule

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loop,
  input  logic [W-1:0] a_bus,
  output logic [W-1:0] keep
);
  // Tracks the A bus until the loop closes, then freezes
  always_ff @(posedge clk) begin
    if (rst)        keep <= '0;
    else if (!loop) keep <= a_bus;
  end
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n
);
  logic         en_ab, en_ba, loop;
  logic [W-1:0] a_bus, b_bus, keep, q_ab, q_ba;
  logic [W-1:0] d_v [NUM_DIR];
  logic [W-1:0] q_v [NUM_DIR];
  logic         cap_v [NUM_DIR];

  assign en_ab = oe_ab;
  assign en_ba = !oe_ba_n;

  assign d_v[DIR_AB]   = a_bus;
  assign d_v[DIR_BA]   = b_bus;
  assign cap_v[DIR_AB] = cap_ab;
  assign cap_v[DIR_BA] = cap_ba;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_capture_reg #(.W(W)) reg_i (
      .clk (clk),
      .rst (rst),
      .cap (cap_v[d]),
      .d   (d_v[d]),
      .q   (q_v[d])
    );
  end

  assign q_ab = q_v[DIR_AB];
  assign q_ba = q_v[DIR_BA];

  xcvr_bus_resolve #(.W(W)) resolve_i (
    .en_ab  (en_ab),
    .en_ba  (en_ba),
    .src_ab (src_sel_e'(sel_ab)),
    .src_ba (src_sel_e'(sel_ba)),
    .a_in   (a_in),
    .b_in   (b_in),
    .q_ab   (q_ab),
    .q_ba   (q_ba),
    .keep   (keep),
    .a_bus  (a_bus),
    .b_bus  (b_bus),
    .loop   (loop)
  );

  xcvr_bus_keeper #(.W(W)) keeper_i (
    .clk   (clk),
    .rst   (rst),
    .loop  (loop),
    .a_bus (a_bus),
    .keep  (keep)
  );

  assign a_oe  = en_ba;
  assign b_oe  = en_ab;
  assign a_out = en_ba ? a_bus : '0;
  assign b_out = en_ab ? b_bus : '0;
endmodule

// File: rtl/bidir_reg_xcvr_chk.sv
module bidir_reg_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         oe_ab,
  input logic         oe_ba_n,
  input logic [W-1:0] q_ab,
  input logic [W-1:0] q_ba
);
  logic [W-1:0] a_res, b_res;
  logic         loop_on;
  assign a_res   = a_oe ? a_out : a_in;
  assign b_res   = b_oe ? b_out : b_in;
  assign loop_on = oe_ab && !sel_ab && !oe_ba_n && !sel_ba;

  p_reset_r1: assert property (@(posedge clk) rst |=> (q_ab == '0 && q_ba == '0));
  p_cap_ab_r2: assert property (@(posedge clk) disable iff (rst)
    cap_ab |=> q_ab == $past(a_res));
  p_keep_ab_r2: assert property (@(posedge clk) disable iff (rst)
    !cap_ab |=> $stable(q_ab));
  p_cap_ba_r3: assert property (@(posedge clk) disable iff (rst)
    cap_ba |=> q_ba == $past(b_res));
  p_keep_ba_r3: assert property (@(posedge clk) disable iff (rst)
    !cap_ba |=> $stable(q_ba));
  p_stored_ab_r4: assert property (@(posedge clk) disable iff (rst)
    (oe_ab && sel_ab) |-> b_out == q_ab);
  p_stored_ba_r5: assert property (@(posedge clk) disable iff (rst)
    (!oe_ba_n && sel_ba) |-> a_out == q_ba);
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!b_oe |-> b_out == '0) and (!a_oe |-> a_out == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    loop_on |=> (!loop_on || ($stable(a_out) && $stable(b_out) && a_out == b_out)));
endmodule

bind bidir_reg_xcvr bidir_reg_xcvr_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe), .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab),
  .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .q_ab(q_ab), .q_ba(q_ba)
);

// File: tb/bidir_reg_xcvr_tb.sv
module bidir_reg_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0, oe_ab = 0, oe_ba_n = 1;

  int n_chk = 0, n_bad = 0;
  logic done = 0;

  // Bench model of register contents
  logic [W-1:0] m_ab = '0, m_ba = '0, m_keep = '0;

  always #2.5 clk = ~clk;

  bidir_reg_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n)
  );

  function automatic logic is_loop();
    return oe_ab && !sel_ab && !oe_ba_n && !sel_ba;
  endfunction

  // Expected value on bus A from the requirement text
  function automatic logic [W-1:0] exp_a();
    if (is_loop()) return m_keep;                  // R9
    if (oe_ba_n) return a_in;                      // not driven
    if (sel_ba) return m_ba;                       // R5 stored
    if (oe_ab) return m_ab;                        // R8 B side stored
    return b_in;                                   // R5 live
  endfunction

  function automatic logic [W-1:0] exp_b();
    if (is_loop()) return m_keep;
    if (!oe_ab) return b_in;
    if (sel_ab) return m_ab;                       // R4 stored
    if (!oe_ba_n) return m_ba;                     // R8
    return a_in;                                   // R4 live
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_b();
    if (!oe_ab) return "R6";
    if (is_loop()) return "R9";
    if (sel_ab && sel_ba && !oe_ba_n) return "R7";
    if (!sel_ab && !oe_ba_n) return "R8";
    return "R4";
  endfunction

  function automatic string tag_a();
    if (oe_ba_n) return "R6";
    if (is_loop()) return "R9";
    if (sel_ab && sel_ba && oe_ab) return "R7";
    if (!sel_ba && oe_ab) return "R8";
    return "R5";
  endfunction

  // Called with inputs settled after a falling edge: check, then clock
  task automatic step();
    logic [W-1:0] ea, eb;
    #1;
    ea = exp_a();
    eb = exp_b();
    chk("R4 b_oe", {7'd0, b_oe}, {7'd0, oe_ab});
    chk("R5 a_oe", {7'd0, a_oe}, {7'd0, !oe_ba_n});
    chk({tag_b(), " b_out"}, b_out, oe_ab ? eb : '0);
    chk({tag_a(), " a_out"}, a_out, !oe_ba_n ? ea : '0);
    @(posedge clk);
    if (cap_ab) m_ab = ea;                         // R2
    if (cap_ba) m_ba = eb;                         // R3
    if (!is_loop()) m_keep = ea;
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic eab, input logic eba, input logic sab, input logic sba);
    oe_ab = eab; oe_ba_n = !eba; sel_ab = sab; sel_ba = sba;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: preload, then reset clears registers
        rst = 0;
        a_in = 8'hC3; b_in = 8'h3C; cap_ab = 1; cap_ba = 1;
        step();
        cap_ab = 0; cap_ba = 0;
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        m_ab = '0; m_ba = '0; m_keep = '0;
        set_ctl(1, 1, 1, 1);
        #1;
        chk("R1 b_out after reset", b_out, '0);
        chk("R1 a_out after reset", a_out, '0);
        step();

        // R2/R3: capture regardless of controls
        set_ctl(0, 0, 1, 0);
        a_in = 8'hA5; b_in = 8'h5A; cap_ab = 1; cap_ba = 1;
        step();
        cap_ab = 0; cap_ba = 0; a_in = 8'h11; b_in = 8'h22;
        step();
        // R7: simultaneous swap of stored words
        set_ctl(1, 1, 1, 1);
        #1;
        chk("R7 swap b_out", b_out, 8'hA5);
        chk("R7 swap a_out", a_out, 8'h5A);
        step();

        // R9: hold after external drivers release
        set_ctl(1, 0, 0, 0);
        a_in = 8'h96; step();
        set_ctl(1, 1, 0, 0);
        a_in = 8'h01; b_in = 8'hFE; step();
        a_in = 8'h77; b_in = 8'h88;
        #1;
        chk("R9 hold a_out", a_out, 8'h96);
        chk("R9 hold b_out", b_out, 8'h96);
        step();

        // All 16 enable/select combinations with random data
        void'($urandom(32'd1234));
        for (int c = 0; c < 16; c++) begin
          for (int k = 0; k < 6; k++) begin
            set_ctl(c[0], c[1], c[2], c[3]);
            a_in = W'($urandom); b_in = W'($urandom);
            cap_ab = 1'($urandom); cap_ba = 1'($urandom);
            step();
          end
        end
        // Free random run
        for (int k = 0; k < 400; k++) begin
          set_ctl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
          a_in = W'($urandom); b_in = W'($urandom);
          cap_ab = 1'($urandom); cap_ba = 1'($urandom);
          step();
        end
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule